// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block picks, for every CPU in a small cluster, the single interrupt it should be told about. Each interrupt carries a per-CPU enable and pending bit, one 8-bit priority shared by all CPUs, and a CPU target mask. Each CPU carries an interface enable, a priority mask and the priority of the interrupt it is servicing now. One global enable gates the whole distributor. A lower priority value is more urgent.

For each CPU the block first filters the interrupts down to candidates. It then reduces the candidates through a binary tree to the most urgent one, and the lower ID wins a tie. The winner is published as that CPU's highest-pending ID only if it passes the priority mask. The CPU's request line rises only if the published interrupt would also pre-empt the running priority. Both results are registered, so every output follows its inputs by exactly one clock.

The surrounding controller feeds the state vectors from its own registers and reads back the ID and request line. Register decode, acknowledge, end-of-interrupt and trigger handling sit outside this block.

Top module: `irq_best_select`

## Requirements
- R1: While reset is asserted, and after it until the first edge with new inputs, every CPU's request line is 0 and every CPU's highest-pending ID is 1023.
- R2: An interrupt is a candidate for a CPU only when both its enable bit and its pending bit for that CPU are 1 (`irq_enable`/`irq_pending` bit `cpu*NUM_IRQ+id`). A CPU with no candidate reports ID 1023.
- R3: An interrupt with ID 32 or above must also have the CPU's bit set in its target mask (`irq_target` bit `id*NUM_CPU+cpu`). IDs 0 to 31 ignore the target mask.
- R4: Among the candidates, the one with the numerically lowest priority value (`irq_prio[id*8 +: 8]`) is chosen.
- R5: When two candidates have equal priority, the lower ID is chosen.
- R6: The chosen ID is published on `cpu_hppi[cpu*10 +: 10]` only if its priority is strictly below the CPU's priority mask (`cpu_pmask[cpu*8 +: 8]`). Otherwise the ID reads 1023, so a mask of 0 blocks every interrupt.
- R7: `cpu_irq_req[cpu]` is 1 only when an ID is published and its priority is strictly below the 9-bit running priority (`cpu_running[cpu*9 +: 9]`). The value 0x100 means idle, and a running priority of 0 never allows a request.
- R8: When `dist_en` is 0, or the CPU's `cpu_if_en` bit is 0, that CPU's request line is 0 and its ID reads 1023.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge, with a latency of one cycle and no change before that edge.
- R10: Each CPU is evaluated independently: one CPU's enables, pending bits, masks, running priority and interface enable do not affect another CPU's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_if_en | input | NUM_CPU | Per-CPU interface enable |
| irq_enable | input | NUM_CPU*NUM_IRQ | Enable bits, bit cpu*NUM_IRQ+id |
| irq_pending | input | NUM_CPU*NUM_IRQ | Pending bits, bit cpu*NUM_IRQ+id |
| irq_prio | input | NUM_IRQ*8 | Priority per interrupt, bits id*8 +: 8 |
| irq_target | input | NUM_IRQ*NUM_CPU | Target mask, bit id*NUM_CPU+cpu |
| cpu_pmask | input | NUM_CPU*8 | Priority mask per CPU |
| cpu_running | input | NUM_CPU*9 | Running priority per CPU, 0x100 when idle |
| cpu_hppi | output | NUM_CPU*10 | Highest-pending ID per CPU, 1023 when none |
| cpu_irq_req | output | NUM_CPU | Interrupt request line per CPU |

## Verification
The bench aims at the strict comparisons. It sets the best priority equal to the mask, and then equal to the running priority. A design that used less-or-equal in either place would publish the ID or raise the line at those points. Ties in priority expose a reduction that favours the right-hand or higher ID. An internal ID with an empty target mask exposes a filter that applies the target check to every ID, because such a design would drop the interrupt. A pending bit set for another CPU exposes a selector that leaks state between CPUs. The bench also checks the output in the cycle before the edge, to catch a design that is purely combinational or that adds a second register stage.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int ID_W         = 10;
    localparam int PRIO_W       = 8;
    localparam int RUN_W        = 9;
    localparam int INTERNAL_IDS = 32;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // lo holds the lower IDs, so it wins a tie.
    function automatic cand_t pick_better(input cand_t lo, input cand_t hi);
        if (lo.vld && (!hi.vld || lo.prio <= hi.prio)) begin
            return lo;
        end
        return hi;
    endfunction

endpackage

// File: rtl/irq_cand_filter.sv
module irq_cand_filter
    import irq_sel_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0] en_row,
    input  logic [NUM_IRQ-1:0] pend_row,
    input  logic [NUM_IRQ-1:0] tgt_col,
    output logic [NUM_IRQ-1:0] cand
);

    localparam logic [NUM_IRQ-1:0] BANKED_MASK = NUM_IRQ'((64'd1 << INTERNAL_IDS) - 64'd1);

    // An interrupt qualifies when it is enabled and pending. A banked ID
    // bypasses the target check.
    assign cand = en_row & pend_row & (tgt_col | BANKED_MASK);

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
    import irq_sel_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output cand_t                     best
);

    localparam int LVL    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int LEAVES = 1 << LVL;

    cand_t work [LEAVES];

    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            if (i < NUM_IRQ) begin
                work[i].vld  = cand[i];
                work[i].prio = prio[i*PRIO_W +: PRIO_W];
                work[i].id   = ID_W'(i);
            end else begin
                work[i] = '0;
            end
        end
        // In-place pairwise reduction. Slot k takes the pair (2k, 2k+1),
        // so lower IDs always sit on the left.
        for (int s = 0; s < LVL; s++) begin
            for (int k = 0; k < LEAVES / 2; k++) begin
                if (k < (LEAVES >> (s + 1))) begin
                    work[k] = pick_better(work[2*k], work[2*k+1]);
                end
            end
        end
        best = work[0];
    end

endmodule

// File: rtl/irq_best_select.sv
module irq_best_select
    import irq_sel_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dist_en,
    input  logic [NUM_CPU-1:0]          cpu_if_en,
    input  logic [NUM_CPU*NUM_IRQ-1:0]  irq_enable,
    input  logic [NUM_CPU*NUM_IRQ-1:0]  irq_pending,
    input  logic [NUM_IRQ*PRIO_W-1:0]   irq_prio,
    input  logic [NUM_IRQ*NUM_CPU-1:0]  irq_target,
    input  logic [NUM_CPU*PRIO_W-1:0]   cpu_pmask,
    input  logic [NUM_CPU*RUN_W-1:0]    cpu_running,
    output logic [NUM_CPU*ID_W-1:0]     cpu_hppi,
    output logic [NUM_CPU-1:0]          cpu_irq_req
);

    typedef struct packed {
        logic [NUM_CPU-1:0]      req;
        logic [NUM_CPU*ID_W-1:0] hppi;
    } out_t;

    localparam out_t OUT_RESET = '{req: '0, hppi: {NUM_CPU{ID_NONE}}};

    cand_t best [NUM_CPU];
    out_t  out_d, out_q;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0] tgt_col;
        logic [NUM_IRQ-1:0] cand;

        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_col
            assign tgt_col[i] = irq_target[i*NUM_CPU + c];
        end

        irq_cand_filter #(.NUM_IRQ(NUM_IRQ)) u_filter (
            .en_row   (irq_enable[c*NUM_IRQ +: NUM_IRQ]),
            .pend_row (irq_pending[c*NUM_IRQ +: NUM_IRQ]),
            .tgt_col  (tgt_col),
            .cand     (cand)
        );

        irq_prio_tree #(.NUM_IRQ(NUM_IRQ)) u_tree (
            .cand (cand),
            .prio (irq_prio),
            .best (best[c])
        );
    end

    always_comb begin
        out_d = OUT_RESET;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (dist_en && cpu_if_en[c] && best[c].vld &&
                (best[c].prio < cpu_pmask[c*PRIO_W +: PRIO_W])) begin
                out_d.hppi[c*ID_W +: ID_W] = best[c].id;
                out_d.req[c] = ({1'b0, best[c].prio} < cpu_running[c*RUN_W +: RUN_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RESET;
        end else begin
            out_q <= out_d;
        end
    end

    assign cpu_hppi    = out_q.hppi;
    assign cpu_irq_req = out_q.req;

endmodule

// File: rtl/irq_best_select_chk.sv
module irq_best_select_chk
    import irq_sel_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dist_en,
    input logic [NUM_CPU-1:0]        cpu_if_en,
    input logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input logic [NUM_CPU*PRIO_W-1:0] cpu_pmask,
    input logic [NUM_CPU*RUN_W-1:0]  cpu_running,
    input logic [NUM_CPU*ID_W-1:0]   cpu_hppi,
    input logic [NUM_CPU-1:0]        cpu_irq_req
);

    logic [NUM_IRQ*PRIO_W-1:0] prio_prev;
    logic [NUM_CPU*PRIO_W-1:0] pmask_prev;
    logic [NUM_CPU*RUN_W-1:0]  run_prev;

    always_ff @(posedge clk) begin
        prio_prev  <= irq_prio;
        pmask_prev <= cpu_pmask;
        run_prev   <= cpu_running;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        logic [ID_W-1:0]   id;
        logic              id_real;
        logic [PRIO_W-1:0] pub_prio;

        assign id      = cpu_hppi[c*ID_W +: ID_W];
        assign id_real = (id != ID_NONE) && (32'(id) < NUM_IRQ);

        always_comb begin
            pub_prio = '1;
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (32'(id) == i) begin
                    pub_prio = prio_prev[i*PRIO_W +: PRIO_W];
                end
            end
        end

        a_r2_id_range: assert property (@(posedge clk) disable iff (!rst_n)
            (id == ID_NONE) || (32'(id) < NUM_IRQ));

        a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!dist_en || !cpu_if_en[c]) |=>
            (!cpu_irq_req[c] && cpu_hppi[c*ID_W +: ID_W] == ID_NONE));

        a_r6_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_pmask[c*PRIO_W +: PRIO_W] == '0) |=> (cpu_hppi[c*ID_W +: ID_W] == ID_NONE));

        a_r6_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
            id_real |-> (pub_prio < pmask_prev[c*PRIO_W +: PRIO_W]));

        a_r7_req_needs_id: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq_req[c] |-> id_real);

        a_r7_req_below_run: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_irq_req[c] && id_real) |-> ({1'b0, pub_prio} < run_prev[c*RUN_W +: RUN_W]));

        a_r7_run_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_running[c*RUN_W +: RUN_W] == '0) |=> !cpu_irq_req[c]);
    end

endmodule

bind irq_best_select irq_best_select_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/irq_best_select_tb.sv
module irq_best_select_tb;

    localparam int NC = 4;
    localparam int NI = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             dist_en;
    logic [NC-1:0]    if_en;
    logic [NC*NI-1:0] en, pend;
    logic [NI*8-1:0]  prio;
    logic [NI*NC-1:0] tgt;
    logic [NC*8-1:0]  pmask;
    logic [NC*9-1:0]  run;
    logic [NC*10-1:0] hppi;
    logic [NC-1:0]    req;

    irq_best_select #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_dut (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(if_en),
        .irq_enable(en), .irq_pending(pend), .irq_prio(prio), .irq_target(tgt),
        .cpu_pmask(pmask), .cpu_running(run), .cpu_hppi(hppi), .cpu_irq_req(req)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [9:0] ida;
        logic [7:0] pa;
        logic [9:0] idb;
        logic [7:0] pb;
        logic       tgt0;
        logic [7:0] pm;
        logic [8:0] rn;
        logic [9:0] exp_id;
        logic       exp_req;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{10'd40, 8'h50, 10'd45, 8'h30, 1'b1, 8'hFF, 9'h100, 10'd45,   1'b1, 4'd4}, // R4
        '{10'd40, 8'h30, 10'd45, 8'h30, 1'b1, 8'hFF, 9'h100, 10'd40,   1'b1, 4'd5}, // R5
        '{10'd50, 8'h20, 10'd60, 8'h10, 1'b0, 8'hFF, 9'h100, 10'd1023, 1'b0, 4'd3}, // R3
        '{10'd5,  8'h20, 10'd60, 8'h10, 1'b0, 8'hFF, 9'h100, 10'd5,    1'b1, 4'd3}, // R3
        '{10'd40, 8'h40, 10'd41, 8'h60, 1'b1, 8'h40, 9'h100, 10'd1023, 1'b0, 4'd6}, // R6
        '{10'd40, 8'h40, 10'd41, 8'h60, 1'b1, 8'h41, 9'h100, 10'd40,   1'b1, 4'd6}, // R6
        '{10'd40, 8'h40, 10'd41, 8'h60, 1'b1, 8'h00, 9'h100, 10'd1023, 1'b0, 4'd6}, // R6
        '{10'd40, 8'h40, 10'd41, 8'h60, 1'b1, 8'hFF, 9'h040, 10'd40,   1'b0, 4'd7}, // R7
        '{10'd40, 8'h40, 10'd41, 8'h60, 1'b1, 8'hFF, 9'h041, 10'd40,   1'b1, 4'd7}, // R7
        '{10'd40, 8'h40, 10'd41, 8'h60, 1'b1, 8'hFF, 9'h000, 10'd40,   1'b0, 4'd7}, // R7
        '{10'd0,  8'hFF, 10'd63, 8'hFE, 1'b1, 8'hFF, 9'h100, 10'd63,   1'b1, 4'd7}, // R7 idle
        '{10'd63, 8'hFF, 10'd0,  8'hFF, 1'b1, 8'hFF, 9'h100, 10'd1023, 1'b0, 4'd6}  // R6
    };

    task automatic chk_id(input string tag, input int cpu, input logic [9:0] exp);
        n_chk++;
        if (hppi[cpu*10 +: 10] !== exp) begin
            n_bad++;
            $display("FAIL %s cpu%0d id actual=%0d expected=%0d", tag, cpu, hppi[cpu*10 +: 10], exp);
        end
    endtask

    task automatic chk_req(input string tag, input int cpu, input logic exp);
        n_chk++;
        if (req[cpu] !== exp) begin
            n_bad++;
            $display("FAIL %s cpu%0d req actual=%b expected=%b", tag, cpu, req[cpu], exp);
        end
    endtask

    task automatic idle_inputs();
        dist_en = 1'b1;
        if_en   = '1;
        en      = '0;
        pend    = '0;
        prio    = '1;
        tgt     = '0;
        pmask   = {NC{8'hFF}};
        run     = {NC{9'h100}};
    endtask

    task automatic set_irq(input int cpu, input int id, input logic [7:0] p, input logic [NC-1:0] tb);
        en[cpu*NI + id]   = 1'b1;
        pend[cpu*NI + id] = 1'b1;
        prio[id*8 +: 8]   = p;
        tgt[id*NC +: NC]  = tb;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        set_irq(0, 40, 8'h10, '1);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset holds outputs even with a live candidate
        for (int c = 0; c < NC; c++) begin
            chk_id("R1 reset", c, 10'd1023);
            chk_req("R1 reset", c, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();
        settle();

        // Vector table, CPU 0
        for (int v = 0; v < 12; v++) begin
            @(negedge clk);
            idle_inputs();
            set_irq(0, int'(VECS[v].ida), VECS[v].pa, VECS[v].tgt0 ? 4'b0011 : 4'b0010);
            set_irq(0, int'(VECS[v].idb), VECS[v].pb, VECS[v].tgt0 ? 4'b0011 : 4'b0010);
            pmask[7:0] = VECS[v].pm;
            run[8:0]   = VECS[v].rn;
            settle();
            chk_id($sformatf("R%0d vec%0d", VECS[v].rq, v), 0, VECS[v].exp_id);
            chk_req($sformatf("R%0d vec%0d", VECS[v].rq, v), 0, VECS[v].exp_req);
        end

        // R2: enabled but not pending
        @(negedge clk);
        idle_inputs();
        en[0*NI + 40] = 1'b1;
        prio[40*8 +: 8] = 8'h10;
        tgt[40*NC +: NC] = '1;
        settle();
        chk_id("R2 enabled-only", 0, 10'd1023);

        // R2: pending but not enabled
        @(negedge clk);
        idle_inputs();
        pend[0*NI + 40] = 1'b1;
        prio[40*8 +: 8] = 8'h10;
        tgt[40*NC +: NC] = '1;
        settle();
        chk_id("R2 pending-only", 0, 10'd1023);

        // R2 / R10: pending for CPU 1 only
        @(negedge clk);
        idle_inputs();
        set_irq(1, 40, 8'h10, '1);
        settle();
        chk_id("R10 other-cpu", 0, 10'd1023);
        chk_req("R10 other-cpu", 0, 1'b0);
        chk_id("R2 cpu1", 1, 10'd40);
        chk_req("R2 cpu1", 1, 1'b1);

        // R8: distributor disabled
        @(negedge clk);
        idle_inputs();
        set_irq(0, 40, 8'h10, '1);
        set_irq(1, 33, 8'h10, '1);
        dist_en = 1'b0;
        settle();
        chk_id("R8 dist-off", 0, 10'd1023);
        chk_req("R8 dist-off", 0, 1'b0);
        chk_id("R8 dist-off", 1, 10'd1023);
        chk_req("R8 dist-off", 1, 1'b0);

        // R8 / R10: CPU 0 interface off, CPU 1 unaffected
        @(negedge clk);
        dist_en = 1'b1;
        if_en[0] = 1'b0;
        settle();
        chk_id("R8 if-off", 0, 10'd1023);
        chk_req("R8 if-off", 0, 1'b0);
        chk_id("R10 cpu1 live", 1, 10'd33);
        chk_req("R10 cpu1 live", 1, 1'b1);

        // R10: per-CPU mask independence
        @(negedge clk);
        idle_inputs();
        set_irq(2, 50, 8'h20, '1);
        set_irq(3, 50, 8'h20, '1);
        pmask[2*8 +: 8] = 8'h00;
        settle();
        chk_id("R10 cpu2 masked", 2, 10'd1023);
        chk_id("R10 cpu3 open", 3, 10'd50);
        chk_req("R10 cpu3 open", 3, 1'b1);

        // R9: one-cycle latency
        @(negedge clk);
        idle_inputs();
        settle();
        @(negedge clk);
        set_irq(0, 40, 8'h10, '1);
        #1;
        chk_id("R9 before edge", 0, 10'd1023);
        chk_req("R9 before edge", 0, 1'b0);
        settle();
        chk_id("R9 after edge", 0, 10'd40);
        chk_req("R9 after edge", 0, 1'b1);

        finish_run();
    end

endmodule